// File: doc/BRIEF.md
# Edge-Triggered Priority Interrupt Controller

This block merges eight peripheral request lines into a single interrupt output for a processor. A line asks for service only when it goes from low to high. The block records that edge as a pending request and raises the processor interrupt. It keeps that interrupt raised for as long as the processor takes to respond. The processor then answers with a one-cycle acknowledge strobe.

The winning line is picked at acknowledge time, not when the edge arrived. The block looks at the live request lines. Among the lines that are pending, unmasked, not blocked by a source already in service and still high, it takes the one with the lowest index. That line's in-service bit is set and its number goes into an identification register. If every candidate line has already dropped back low, the block reports a spurious interrupt with identifier 7 instead.

The processor reads the identification register through a read strobe. When its handler is done, it pulses end-of-interrupt. A mask register stops chosen lines from raising the interrupt. Edges on masked lines are still recorded.

Top module: `edge_pic`

## Requirements
- R1: After reset, `cpu_irq` is 0, no line is pending, in service or masked, and a read returns 0x07.
- R2: A low-to-high transition on an unmasked `req_in` line, with no equal-or-higher-priority source in service, makes `cpu_irq` 1 after the clock edge that samples it. A line that is already high and has no new edge raises nothing.
- R3: A line that stays high after it was serviced and ended raises no new request. A new request needs the line to fall and then rise again.
- R4: On `ack`, the block picks the lowest-index line that is pending, unmasked, not blocked and high on `req_in` at that cycle. It sets that line's in-service bit and clears its pending flag. Reads then return {bit 7 = 1, bits 6:3 = 0, bits 2:0 = line index}.
- R5: If a higher-priority line rises after a lower-priority one but before `ack`, the higher-priority line is the one serviced.
- R6: If no candidate line is high at `ack`, reads return 0x07 (valid bit 0, identifier 7). No in-service bit is set, and the pending flag of the highest-priority eligible line is cleared.
- R7: Line 0 has the highest priority and line 7 the lowest. While a line is in service, pending requests of equal or lower priority do not raise `cpu_irq`. A higher-priority line still does, so service can nest.
- R8: An `eoi` strobe clears only the highest-priority in-service bit. `cpu_irq` comes back if an unblocked, unmasked request is still pending.
- R9: Writing the mask with `mask_we` blocks the lines whose mask bits are 1 from raising `cpu_irq`. Their edges stay pending, so clearing the mask bit raises `cpu_irq`.
- R10: `rd_data` is 0 whenever `rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 8 | Peripheral request lines, bit 0 has the highest priority |
| mask_we | input | 1 | Loads `mask_wdata` into the mask register |
| mask_wdata | input | 8 | New mask value, 1 blocks the line |
| ack | input | 1 | One-cycle acknowledge strobe from the processor |
| eoi | input | 1 | One-cycle end-of-interrupt strobe |
| rd | input | 1 | Read strobe for the identification register |
| rd_data | output | 8 | Identification value while `rd` is high, else 0 |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The edge register, pending flags, in-service bits, mask and identification register all update on the clock edge that samples the input. So `cpu_irq` and the read value reflect an edge, acknowledge, end-of-interrupt or mask write one edge after the stimulus is applied. `rd_data` follows `rd` with no clock at all. The bench changes inputs 1 ns after a rising edge and makes its directed checks after the following edge. A behavioural model advances on each rising edge and is compared with `cpu_irq` and `rd_data` on every falling edge, mid-cycle, where both are settled.

// File: rtl/edge_pic_pkg.sv
package edge_pic_pkg;
    localparam int N_LINES = 8;
    localparam int ID_W    = $clog2(N_LINES);
    localparam int RD_W    = 8;
    localparam int PAD_W   = RD_W - 1 - ID_W;
    localparam logic [ID_W-1:0] SPURIOUS_ID = ID_W'(N_LINES - 1);

    typedef logic [N_LINES-1:0] line_vec_t;

    typedef enum logic [1:0] {
        ACK_NONE,
        ACK_GRANT,
        ACK_SPURIOUS
    } ack_kind_t;

    typedef struct packed {
        logic            found;
        logic [ID_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic             valid;
        logic [PAD_W-1:0] pad;
        logic [ID_W-1:0]  id;
    } ident_t;

    // lowest set index wins
    function automatic pick_t pick_first(line_vec_t v);
        pick_t p;
        p = '0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.found = 1'b1;
                p.idx   = ID_W'(i);
            end
        end
        return p;
    endfunction

    // line i may interrupt only if no line at index <= i is in service
    function automatic line_vec_t allow_below(line_vec_t isr);
        line_vec_t a;
        logic      blocked;
        blocked = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            blocked = blocked | isr[i];
            a[i]    = ~blocked;
        end
        return a;
    endfunction

    function automatic line_vec_t onehot(logic [ID_W-1:0] idx);
        return line_vec_t'(1) << idx;
    endfunction
endpackage

// File: rtl/edge_pic_capture.sv
module edge_pic_capture
    import edge_pic_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req_in,
    input  line_vec_t pend_clr,
    output line_vec_t pend_q,
    output line_vec_t req_q
);
    line_vec_t rise;

    assign rise = req_in & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            pend_q <= '0;
        end else begin
            req_q  <= req_in;
            pend_q <= (pend_q & ~pend_clr) | rise;
        end
    end

    // R2: every sampled rising edge is pending on the next cycle
    a_r2_edge_recorded: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((pend_q & $past(rise)) == $past(rise)));

    // R3: with no edge, no pending flag can appear
    a_r3_no_level_request: assert property (@(posedge clk) disable iff (rst)
        (rise == '0) |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/edge_pic_arbiter.sv
module edge_pic_arbiter
    import edge_pic_pkg::*;
(
    input  line_vec_t       req_in,
    input  line_vec_t       pend,
    input  line_vec_t       mask,
    input  line_vec_t       isr,
    input  logic            ack,
    output logic            cpu_irq,
    output ack_kind_t       kind,
    output logic [ID_W-1:0] grant_idx,
    output line_vec_t       pend_clr
);
    line_vec_t eligible;
    line_vec_t live;
    pick_t     pick_live;
    pick_t     pick_elig;

    assign eligible  = pend & ~mask & allow_below(isr);
    assign live      = eligible & req_in;
    assign pick_live = pick_first(live);
    assign pick_elig = pick_first(eligible);
    assign cpu_irq   = |eligible;

    always_comb begin
        kind      = ACK_NONE;
        grant_idx = pick_live.idx;
        pend_clr  = '0;
        if (ack) begin
            if (pick_live.found) begin
                kind     = ACK_GRANT;
                pend_clr = onehot(pick_live.idx);
            end else begin
                kind = ACK_SPURIOUS;
                if (pick_elig.found) begin
                    pend_clr = onehot(pick_elig.idx);
                end
            end
        end
    end
endmodule

// File: rtl/edge_pic_service.sv
module edge_pic_service
    import edge_pic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ack_kind_t       kind,
    input  logic [ID_W-1:0] grant_idx,
    input  logic            eoi,
    input  logic            mask_we,
    input  line_vec_t       mask_wdata,
    input  logic            rd,
    output line_vec_t       isr_q,
    output line_vec_t       mask_q,
    output logic [RD_W-1:0] rd_data
);
    ident_t    ident_q;
    pick_t     top_isr;
    line_vec_t isr_set;
    line_vec_t isr_end;

    assign top_isr = pick_first(isr_q);
    assign isr_set = (kind == ACK_GRANT) ? onehot(grant_idx) : '0;
    assign isr_end = (eoi && top_isr.found) ? onehot(top_isr.idx) : '0;
    assign rd_data = rd ? RD_W'(ident_q) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q   <= '0;
            mask_q  <= '0;
            ident_q <= '{valid: 1'b0, pad: '0, id: SPURIOUS_ID};
        end else begin
            isr_q <= (isr_q & ~isr_end) | isr_set;
            if (mask_we) begin
                mask_q <= mask_wdata;
            end
            case (kind)
                ACK_GRANT:    ident_q <= '{valid: 1'b1, pad: '0, id: grant_idx};
                ACK_SPURIOUS: ident_q <= '{valid: 1'b0, pad: '0, id: SPURIOUS_ID};
                default:      ident_q <= ident_q;
            endcase
        end
    end

    // R4: a grant leaves the chosen line in service
    a_r4_grant_in_service: assert property (@(posedge clk) disable iff (rst)
        (kind == ACK_GRANT) |=> isr_q[$past(grant_idx)]);

    // R6: a spurious acknowledge sets no in-service bit
    a_r6_spurious_no_isr: assert property (@(posedge clk) disable iff (rst)
        (kind == ACK_SPURIOUS) |=> ((isr_q & ~$past(isr_q)) == '0));

    // R8: end-of-interrupt without a grant removes exactly one bit
    a_r8_eoi_single_clear: assert property (@(posedge clk) disable iff (rst)
        (eoi && kind != ACK_GRANT && isr_q != '0)
        |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

// File: rtl/edge_pic.sv
module edge_pic
    import edge_pic_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_LINES-1:0]         req_in,
    input  logic                       mask_we,
    input  logic [N_LINES-1:0]         mask_wdata,
    input  logic                       ack,
    input  logic                       eoi,
    input  logic                       rd,
    output logic [RD_W-1:0]            rd_data,
    output logic                       cpu_irq
);
    line_vec_t       pend_q;
    line_vec_t       req_q;
    line_vec_t       pend_clr;
    line_vec_t       isr_q;
    line_vec_t       mask_q;
    ack_kind_t       kind;
    logic [ID_W-1:0] grant_idx;

    edge_pic_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .req_in   (req_in),
        .pend_clr (pend_clr),
        .pend_q   (pend_q),
        .req_q    (req_q)
    );

    edge_pic_arbiter u_arbiter (
        .req_in    (req_in),
        .pend      (pend_q),
        .mask      (mask_q),
        .isr       (isr_q),
        .ack       (ack),
        .cpu_irq   (cpu_irq),
        .kind      (kind),
        .grant_idx (grant_idx),
        .pend_clr  (pend_clr)
    );

    edge_pic_service u_service (
        .clk        (clk),
        .rst        (rst),
        .kind       (kind),
        .grant_idx  (grant_idx),
        .eoi        (eoi),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .rd         (rd),
        .isr_q      (isr_q),
        .mask_q     (mask_q),
        .rd_data    (rd_data)
    );

    // R9: the interrupt is only raised by an unmasked pending line
    a_r9_irq_needs_unmasked: assert property (@(posedge clk) disable iff (rst)
        cpu_irq |-> ((pend_q & ~mask_q) != '0));

    // R7: an acknowledge that grants leaves no in-service bit below it uncovered
    a_r7_grant_outranks: assert property (@(posedge clk) disable iff (rst)
        (kind == ACK_GRANT) |=> (($past(isr_q) & onehot($past(grant_idx))) == '0));

    logic unused_req_q;
    assign unused_req_q = ^req_q;
endmodule

// File: tb/edge_pic_bench.sv
`timescale 1ns/1ps
module edge_pic_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req = '0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       ack = 1'b0;
    logic       eoi = 1'b0;
    logic       rd = 1'b1;
    logic [7:0] rd_data;
    logic       cpu_irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    edge_pic u_edge_pic (
        .clk(clk), .rst(rst), .req_in(req), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .ack(ack), .eoi(eoi), .rd(rd),
        .rd_data(rd_data), .cpu_irq(cpu_irq)
    );

    // behavioural reference
    logic [7:0] m_prev, m_pend, m_isr, m_mask, m_ident;

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] m_eligible();
        int k;
        logic [7:0] e;
        k = lowest(m_isr);
        if (k < 0) k = 8;
        e = '0;
        for (int i = 0; i < 8; i++) e[i] = m_pend[i] & ~m_mask[i] & (i < k);
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_prev = '0; m_pend = '0; m_isr = '0; m_mask = '0; m_ident = 8'h07;
        end else begin
            logic [7:0] elig, clr, set, endc;
            int j;
            elig = m_eligible();
            clr = '0; set = '0; endc = '0;
            if (ack) begin
                j = lowest(elig & req);
                if (j >= 0) begin
                    set[j] = 1'b1; clr[j] = 1'b1; m_ident = 8'h80 | 8'(j);
                end else begin
                    m_ident = 8'h07;
                    j = lowest(elig);
                    if (j >= 0) clr[j] = 1'b1;
                end
            end
            if (eoi) begin
                j = lowest(m_isr);
                if (j >= 0) endc[j] = 1'b1;
            end
            m_pend = (m_pend & ~clr) | (req & ~m_prev);
            m_isr  = (m_isr & ~endc) | set;
            if (mask_we) m_mask = mask_wdata;
            m_prev = req;
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_req, " model irq"}, {7'd0, cpu_irq}, {7'd0, |m_eligible()});
            chk({cur_req, " model rd"}, rd_data, rd ? m_ident : 8'h00);
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic pulse_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic pulse_eoi();
        eoi = 1'b1; tick(); eoi = 1'b0;
    endtask

    initial begin
        tick(2);
        rst = 1'b0;
        tick();
        chk("R1 irq", {7'd0, cpu_irq}, 8'h00);
        chk("R1 rd", rd_data, 8'h07);

        cur_req = "R2";
        req[3] = 1'b1;
        chk("R2 irq before edge", {7'd0, cpu_irq}, 8'h00);
        tick();
        chk("R2 irq after edge", {7'd0, cpu_irq}, 8'h01);

        cur_req = "R4";
        pulse_ack();
        chk("R4 ident", rd_data, 8'h83);
        chk("R4 irq drops", {7'd0, cpu_irq}, 8'h00);

        cur_req = "R3";
        pulse_eoi();
        tick(3);
        chk("R3 held line silent", {7'd0, cpu_irq}, 8'h00);
        req[3] = 1'b0; tick();
        req[3] = 1'b1; tick();
        chk("R3 re-rise requests", {7'd0, cpu_irq}, 8'h01);
        pulse_ack(); pulse_eoi();
        req = '0; tick(2);

        cur_req = "R5";
        req[5] = 1'b1; tick(2);
        req[1] = 1'b1; tick(2);
        pulse_ack();
        chk("R5 higher wins", rd_data, 8'h81);
        cur_req = "R7";
        chk("R7 lower blocked", {7'd0, cpu_irq}, 8'h00);
        cur_req = "R8";
        pulse_eoi();
        chk("R8 irq returns", {7'd0, cpu_irq}, 8'h01);
        pulse_ack();
        chk("R8 next ident", rd_data, 8'h85);
        pulse_eoi();
        req = '0; tick(2);

        cur_req = "R6";
        req[4] = 1'b1; tick(2);
        req[4] = 1'b0; tick();
        chk("R6 irq while pending", {7'd0, cpu_irq}, 8'h01);
        pulse_ack();
        chk("R6 spurious id", rd_data, 8'h07);
        tick();
        chk("R6 pending cleared", {7'd0, cpu_irq}, 8'h00);
        req[6] = 1'b1; tick();
        pulse_ack();
        chk("R6 no isr left behind", rd_data, 8'h86);
        pulse_eoi();
        req = '0; tick(2);

        cur_req = "R7";
        req[2] = 1'b1; tick();
        pulse_ack();
        chk("R7 first grant", rd_data, 8'h82);
        req[6] = 1'b1; tick(2);
        chk("R7 lower masked by isr", {7'd0, cpu_irq}, 8'h00);
        req[0] = 1'b1; tick();
        chk("R7 higher nests", {7'd0, cpu_irq}, 8'h01);
        pulse_ack();
        chk("R7 nested id", rd_data, 8'h80);
        cur_req = "R8";
        pulse_eoi();
        chk("R8 only top cleared", {7'd0, cpu_irq}, 8'h00);
        pulse_eoi();
        chk("R8 second eoi frees", {7'd0, cpu_irq}, 8'h01);
        pulse_ack();
        chk("R8 grant after", rd_data, 8'h86);
        pulse_eoi();
        req = '0; tick(2);

        cur_req = "R9";
        mask_wdata = 8'h10; mask_we = 1'b1; tick(); mask_we = 1'b0;
        req[4] = 1'b1; tick(3);
        chk("R9 masked silent", {7'd0, cpu_irq}, 8'h00);
        mask_wdata = 8'h00; mask_we = 1'b1; tick(); mask_we = 1'b0;
        chk("R9 unmask raises", {7'd0, cpu_irq}, 8'h01);
        pulse_ack();
        chk("R9 grant", rd_data, 8'h84);
        pulse_eoi();

        cur_req = "R10";
        rd = 1'b0; tick();
        chk("R10 rd low", rd_data, 8'h00);
        rd = 1'b1; tick();
        chk("R10 rd high", rd_data, 8'h84);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule